// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures fan speed on two independent channels. Each channel owns a 16-bit down-counter that starts at 0xFFFF and steps down by one on every prescaled tick. A tachometer edge on the channel's selected fan input ends the measurement. The remaining count is then stored in the channel's capture register. A fan gives two tach pulses per revolution, so the distance from 0xFFFF to the captured value covers half a revolution, counted in prescaled ticks.

A measurement can end in one of three ways. A tach edge gives a good capture. A compare stop fires when the counter reaches a point set by the channel's compare configuration and target. An underflow fires when the counter would go below zero. Each way of ending sets its own pending flag. After any of them, the counter reloads to 0xFFFF and a new measurement begins. The single interrupt output is high while any pending flag is set and its enable bit is also set. Software clears a pending flag with a one-cycle pulse on the matching clear bit.

All controls are plain level inputs. The block has no data stream, so it has no valid/ready handshake. The capture registers and pending flags hold their values until they are overwritten or cleared.

Top module: `fan_tach_timer`

## Requirements
- R1: A channel runs only while `mode_en`, its `ch_en` bit and its `clk_sel` bit are all 1. While a channel is stopped, its counter stays at 0xFFFF. While it runs, the counter decrements once every `prescale`+1 clock cycles. The prescaler restarts from zero whenever `mode_en` is 0.
- R2: Channel A takes `tach_in[0]` when `in_sel[0]`=0 and `tach_in[2]` when `in_sel[0]`=1. Channel B takes `tach_in[1]` or `tach_in[3]` under `in_sel[1]` in the same way. The unselected input has no effect. A channel's input is synchronized by two flops. When `edge_fall` for the channel is 0 only rising edges count, and when it is 1 only falling edges count.
- R3: On a tach edge, the channel's capture register takes the count value. The pending flag for a capture is bit 0 for A and bit 1 for B. The outputs show the result on the third rising clock edge after the tach input changes.
- R4: When a tick arrives while the count is 0, the measurement ends as an underflow. This sets pending bit 2 for A or bit 3 for B and leaves the capture register unchanged.
- R5: `cmp_cfg[3:0]` configures channel A and `cmp_cfg[7:4]` configures channel B. Within each nibble, bit 3 is high stop, bit 2 is equal stop and bit 1 is below stop. Bit 0 is ignored. High stop fires as soon as the count is 0xFFFF. If high stop is off, equal stop fires when the count equals the target. If both are off, below stop fires when the count equals target minus one, and only when the target is non-zero. A compare stop sets pending bit 4 for A or bit 5 for B and leaves the capture register unchanged.
- R6: After any outcome, the counter shows 0xFFFF on the next clock edge.
- R7: `irq` is 1 exactly when some pending bit is set and its `irq_en` bit is also set. A 1 on a `pend_clr` bit clears that pending bit at the next edge. If a new outcome sets the same bit in that cycle, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Global measurement enable |
| ch_en | input | 2 | Per-channel enable |
| clk_sel | input | 2 | Per-channel tick select (0 = stopped) |
| edge_fall | input | 2 | Per-channel edge polarity (0 rising, 1 falling) |
| in_sel | input | 2 | Per-channel fan input select |
| tach_in | input | 4 | Fan tach inputs |
| prescale | input | 8 | Tick divider minus one |
| cmp_cfg | input | 8 | Compare configuration, one nibble per channel |
| cmp_tgt | input | 32 | Compare targets, A in [15:0], B in [31:16] |
| irq_en | input | 6 | Interrupt enable per pending bit |
| pend_clr | input | 6 | Pending clear pulse per bit |
| count | output | 32 | Live counters, A in [15:0], B in [31:16] |
| capture | output | 32 | Capture registers, A in [15:0], B in [31:16] |
| pending | output | 6 | Pending flags |
| irq | output | 1 | Interrupt request |

## Verification
A tach input change shows up in `capture` and `pending` on the third rising edge after it, because of two synchronizer flops and one outcome register. The bench therefore counts rising edges from the change and samples on the falling edge that follows the third one. A compare or underflow flag appears one edge after the cycle in which the counter holds the stop value. The expected counts come from the number of prescaled ticks that fall between the last reload and the cycle before the capture. The bench samples one cycle before each due edge and again right after it, so an outcome that arrives one cycle early or late fails a check.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  typedef enum logic [1:0] {
    END_NONE      = 2'd0,
    END_CAPTURE   = 2'd1,
    END_UNDERFLOW = 2'd2,
    END_COMPARE   = 2'd3
  } meas_end_e;

  typedef struct packed {
    logic stop_high;
    logic stop_equal;
    logic stop_below;
  } stop_cfg_t;

  function automatic stop_cfg_t decode_nibble(input logic [3:0] nib);
    stop_cfg_t c;
    c.stop_high  = nib[3];
    c.stop_equal = nib[2];
    c.stop_below = nib[1];
    return c;
  endfunction

endpackage

// File: rtl/fan_tach_prescaler.sv
module fan_tach_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;
  logic             wrap;

  assign wrap = (div_q >= prescale);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (!run)   div_q <= '0;
    else if (wrap)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/fan_tach_edge_sync.sv
module fan_tach_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic edge_seen
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= cur;
    end
  end

  assign edge_seen = fall_sel ? (prev_q && !cur) : (!prev_q && cur);
endmodule

// File: rtl/fan_tach_channel.sv
module fan_tach_channel
  import fan_tach_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             edge_seen,
  input  stop_cfg_t        cfg,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] captured,
  output meas_end_e        ending
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             stop_hit;

  always_comb begin
    if (cfg.stop_high)       stop_hit = (cnt_q == TOP);
    else if (cfg.stop_equal) stop_hit = (cnt_q == target);
    else if (cfg.stop_below) stop_hit = (target != '0) && (cnt_q == target - 1'b1);
    else                     stop_hit = 1'b0;
  end

  always_comb begin
    if (!run)                      ending = END_NONE;
    else if (stop_hit)             ending = END_COMPARE;
    else if (edge_seen)            ending = END_CAPTURE;
    else if (tick && cnt_q == '0)  ending = END_UNDERFLOW;
    else                           ending = END_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= TOP;
    else if (!run)               cnt_q <= TOP;
    else if (ending != END_NONE) cnt_q <= TOP;
    else if (tick)               cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cap_q <= '0;
    else if (ending == END_CAPTURE) cap_q <= cnt_q;
  end

  assign count    = cnt_q;
  assign captured = cap_q;
endmodule

// File: rtl/fan_tach_timer.sv
module fan_tach_timer
  import fan_tach_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_en,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0]       clk_sel,
  input  logic [NUM_CH-1:0]       edge_fall,
  input  logic [NUM_CH-1:0]       in_sel,
  input  logic [2*NUM_CH-1:0]     tach_in,
  input  logic [PRE_W-1:0]        prescale,
  input  logic [4*NUM_CH-1:0]     cmp_cfg,
  input  logic [NUM_CH*CNT_W-1:0] cmp_tgt,
  input  logic [3*NUM_CH-1:0]     irq_en,
  input  logic [3*NUM_CH-1:0]     pend_clr,
  output logic [NUM_CH*CNT_W-1:0] count,
  output logic [NUM_CH*CNT_W-1:0] capture,
  output logic [3*NUM_CH-1:0]     pending,
  output logic                    irq
);
  localparam int PEND_W = 3 * NUM_CH;
  localparam int OFS_UF = NUM_CH;
  localparam int OFS_CP = 2 * NUM_CH;

  logic              tick;
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_set;

  fan_tach_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (mode_en),
    .prescale (prescale),
    .tick     (tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic      run;
    logic      src;
    logic      edge_seen;
    meas_end_e ending;

    assign run = mode_en && ch_en[g] && clk_sel[g];
    assign src = in_sel[g] ? tach_in[g + NUM_CH] : tach_in[g];

    fan_tach_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (src),
      .fall_sel  (edge_fall[g]),
      .edge_seen (edge_seen)
    );

    fan_tach_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .edge_seen (edge_seen),
      .cfg       (decode_nibble(cmp_cfg[4*g +: 4])),
      .target    (cmp_tgt[g*CNT_W +: CNT_W]),
      .count     (count[g*CNT_W +: CNT_W]),
      .captured  (capture[g*CNT_W +: CNT_W]),
      .ending    (ending)
    );

    assign pend_set[g]          = (ending == END_CAPTURE);
    assign pend_set[g + OFS_UF] = (ending == END_UNDERFLOW);
    assign pend_set[g + OFS_CP] = (ending == END_COMPARE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~pend_clr) | pend_set;
  end

  assign pending = pend_q;
  assign irq     = |(pend_q & irq_en);
endmodule

// File: rtl/fan_tach_checker.sv
module fan_tach_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mode_en,
  input logic [NUM_CH*CNT_W-1:0] count,
  input logic [NUM_CH*CNT_W-1:0] capture,
  input logic [3*NUM_CH-1:0]     pending
);
  logic [CNT_W-1:0] cnt_a;
  logic [CNT_W-1:0] cap_a;

  assign cnt_a = count[CNT_W-1:0];
  assign cap_a = capture[CNT_W-1:0];

  AST_STOPPED_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> cnt_a == {CNT_W{1'b1}}); // R1

  AST_STEP_OR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_a) |-> (cnt_a == $past(cnt_a) - 1'b1 || cnt_a == {CNT_W{1'b1}})); // R6

  AST_CAPTURE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_a) |-> pending[0]); // R3

  AST_UNDERFLOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending[NUM_CH]) |-> $past(cnt_a) == '0); // R4

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({$rose(pending[0]), $rose(pending[NUM_CH]), $rose(pending[2*NUM_CH])}) <= 1); // R5
endmodule

bind fan_tach_timer fan_tach_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_en (mode_en),
  .count   (count),
  .capture (capture),
  .pending (pending)
);

// File: tb/test_fan_tach_timer.sv
module test_fan_tach_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0;
  logic [1:0]  ch_en = '0, clk_sel = '0, edge_fall = '0, in_sel = '0;
  logic [3:0]  tach_in = '0;
  logic [7:0]  prescale = '0;
  logic [7:0]  cmp_cfg = '0;
  logic [31:0] cmp_tgt = '0;
  logic [5:0]  irq_en = '0, pend_clr = '0;
  logic [31:0] count, capture;
  logic [5:0]  pending;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  fan_tach_timer i_fan_tach_timer (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .ch_en(ch_en), .clk_sel(clk_sel),
    .edge_fall(edge_fall), .in_sel(in_sel), .tach_in(tach_in), .prescale(prescale),
    .cmp_cfg(cmp_cfg), .cmp_tgt(cmp_tgt), .irq_en(irq_en), .pend_clr(pend_clr),
    .count(count), .capture(capture), .pending(pending), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic to_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_cap(input int base, input int r, input int c, input int q);
    return 16'hFFFF - 16'(((c - 1 - base) / q) - ((r - base) / q));
  endfunction

  task automatic idle();
    @(negedge clk);
    mode_en = 1'b0; ch_en = '0; clk_sel = '0; cmp_cfg = '0; irq_en = '0;
    pend_clr = '1;
    @(negedge clk);
    pend_clr = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int e, r, m, q;
    logic [15:0] cap_keep;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", count, 32'hFFFF_FFFF);
    chk("R3 reset capture", capture, 32'h0);
    chk("R7 reset pending/irq", {26'd0, pending}, 32'd0);
    chk("R7 reset irq", {31'd0, irq}, 32'd0);

    // R3 / R6 / R7: random prescale and edge spacing on channel A
    q = $urandom_range(1, 4);
    prescale = 8'(q - 1);
    irq_en = 6'b000001;
    ch_en = 2'b11; clk_sel = 2'b11; mode_en = 1'b1;
    e = cyc; r = e;
    for (int k = 0; k < 20; k++) begin
      repeat ($urandom_range(4, 40)) @(negedge clk);
      m = cyc;
      tach_in[0] = 1'b1;
      to_cyc(m + 3);
      chk("R3 capture value", {16'd0, capture[15:0]}, {16'd0, exp_cap(e, r, m + 3, q)});
      chk("R3 capture pending", {31'd0, pending[0]}, 32'd1);
      chk("R6 reload after capture", {16'd0, count[15:0]}, 32'h0000_FFFF);
      chk("R7 irq on enabled pending", {31'd0, irq}, 32'd1);
      pend_clr = 6'b000001; tach_in[0] = 1'b0;
      @(negedge clk);
      pend_clr = '0;
      chk("R7 clear pending", {31'd0, pending[0]}, 32'd0);
      chk("R7 irq low after clear", {31'd0, irq}, 32'd0);
      r = m + 3;
    end
    idle();

    // R1: prescaled stepping, and stopped channel
    prescale = 8'd2; ch_en = 2'b01; clk_sel = 2'b01; mode_en = 1'b1;
    e = cyc;
    to_cyc(e + 2);
    chk("R1 no tick yet", {16'd0, count[15:0]}, 32'h0000_FFFF);
    to_cyc(e + 10);
    chk("R1 prescaled step", {16'd0, count[15:0]}, 32'h0000_FFFC);
    idle();
    cap_keep = capture[15:0];
    ch_en = 2'b01; clk_sel = 2'b00; mode_en = 1'b1; prescale = 8'd0;
    repeat (3) @(negedge clk);
    tach_in[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 stopped holds top", {16'd0, count[15:0]}, 32'h0000_FFFF);
    chk("R1 stopped no outcome", {26'd0, pending}, 32'd0);
    chk("R1 stopped capture kept", {16'd0, capture[15:0]}, {16'd0, cap_keep});
    tach_in[0] = 1'b0;
    idle();

    // R2: channel B on alternate input, falling edges
    in_sel = 2'b10; edge_fall = 2'b10; tach_in = 4'b0000;
    repeat (4) @(negedge clk);
    ch_en = 2'b10; clk_sel = 2'b10; mode_en = 1'b1;
    e = cyc;
    repeat (10) @(negedge clk);
    tach_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    tach_in[1] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 unselected input ignored", {31'd0, pending[1]}, 32'd0);
    m = cyc; tach_in[3] = 1'b1;
    to_cyc(m + 3);
    chk("R2 rising ignored when falling selected", {31'd0, pending[1]}, 32'd0);
    m = cyc; tach_in[3] = 1'b0;
    to_cyc(m + 2);
    chk("R3 not yet at second edge", {31'd0, pending[1]}, 32'd0);
    to_cyc(m + 3);
    chk("R2 falling edge captured B", {31'd0, pending[1]}, 32'd1);
    chk("R2 capture B value", {16'd0, capture[31:16]}, {16'd0, exp_cap(e, e, m + 3, 1)});
    in_sel = '0; edge_fall = '0;
    idle();

    // R5: compare stops
    cap_keep = capture[15:0];
    cmp_tgt = {16'hFFF8, 16'hFFF0};
    cmp_cfg = 8'h04; ch_en = 2'b01; clk_sel = 2'b01; mode_en = 1'b1; e = cyc;
    to_cyc(e + 15); chk("R5 equal not early", {31'd0, pending[4]}, 32'd0);
    to_cyc(e + 16); chk("R5 equal stop", {31'd0, pending[4]}, 32'd1);
    chk("R5 capture unchanged", {16'd0, capture[15:0]}, {16'd0, cap_keep});
    idle();
    cmp_cfg = 8'h02; ch_en = 2'b01; clk_sel = 2'b01; mode_en = 1'b1; e = cyc;
    to_cyc(e + 16); chk("R5 below not early", {31'd0, pending[4]}, 32'd0);
    to_cyc(e + 17); chk("R5 below stop", {31'd0, pending[4]}, 32'd1);
    idle();
    cmp_cfg = 8'h07; ch_en = 2'b01; clk_sel = 2'b01; mode_en = 1'b1; e = cyc;
    to_cyc(e + 16); chk("R5 equal beats below", {31'd0, pending[4]}, 32'd1);
    idle();
    cmp_cfg = 8'h0C; ch_en = 2'b01; clk_sel = 2'b01; mode_en = 1'b1; e = cyc;
    to_cyc(e + 1); chk("R5 high stops at once", {31'd0, pending[4]}, 32'd1);
    idle();
    cmp_tgt[15:0] = 16'h0000;
    cmp_cfg = 8'h02; ch_en = 2'b01; clk_sel = 2'b01; mode_en = 1'b1; e = cyc;
    to_cyc(e + 40); chk("R5 below needs nonzero target", {31'd0, pending[4]}, 32'd0);
    idle();
    cmp_cfg = 8'h40; ch_en = 2'b10; clk_sel = 2'b10; mode_en = 1'b1; e = cyc;
    to_cyc(e + 7); chk("R5 B nibble not early", {31'd0, pending[5]}, 32'd0);
    to_cyc(e + 8); chk("R5 B nibble equal stop", {31'd0, pending[5]}, 32'd1);
    chk("R5 A untouched by B nibble", {31'd0, pending[4]}, 32'd0);
    idle();

    // R4 / R6 / R7: underflow on both channels, set beats clear
    cap_keep = capture[15:0];
    prescale = 8'd0; ch_en = 2'b11; clk_sel = 2'b11; mode_en = 1'b1; e = cyc;
    to_cyc(e + 65535);
    chk("R4 not before zero tick", {29'd0, pending[3:2], 1'b0}, 32'd0);
    pend_clr = 6'b000100;
    @(negedge clk);
    pend_clr = '0;
    chk("R4 underflow A", {31'd0, pending[2]}, 32'd1);
    chk("R4 underflow B", {31'd0, pending[3]}, 32'd1);
    chk("R4 capture unchanged", {16'd0, capture[15:0]}, {16'd0, cap_keep});
    chk("R6 reload after underflow", {16'd0, count[15:0]}, 32'h0000_FFFF);
    irq_en = 6'b000011; #1;
    chk("R7 masked pending no irq", {31'd0, irq}, 32'd0);
    irq_en = 6'b001000; #1;
    chk("R7 enabled underflow irq", {31'd0, irq}, 32'd1);
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule